// File: doc/BRIEF.md
# I2C Serial Memory Slave Address Front End

This block is the receive front end of a serial memory slave on a two-wire I2C bus. It brings the raw clock and data lines into the system clock domain and watches them for START and STOP conditions. After a START it shifts in the first byte, which is the device select code. It compares that code against two accepted device type codes and against a three-bit slave address taken from strap pins.

When the select code matches, the block pulls the data line low to acknowledge it. For a read access it then reports the access at once. For a write access it first receives one word address byte, acknowledges that byte, and then reports the access. The report is a single-cycle strobe that carries the region selected (main memory or identification page), the direction, and the captured address.

Because the address comes from strap pins, up to eight of these slaves can share one bus. A STOP, or a repeated START, aborts whatever byte is in progress.

Top module: `i2c_sel_frontend`

## Requirements
- R1: Before any START has been seen, SCL pulses with data are ignored: sda_oe stays 0 and acc_valid never pulses.
- R2: The select byte arrives most significant bit first. Bits [7:4] hold the device type, bits [3:1] hold the slave address, and bit [0] is the direction, where 1 means read and 0 means write.
- R3: Type 4'b1010 is accepted as a main memory access and reported as acc_region=0. Type 4'b1011 is accepted as an identification page access and reported as acc_region=1. Any other type is not acknowledged.
- R4: Select bits [3:1] must equal chip_sel[2:0], or the byte is not acknowledged.
- R5: sda_oe rises only after the SCL falling edge that ends bit 8 of an accepted byte. It falls after the SCL falling edge that ends bit 9. It never changes while SCL is high, and it is 0 throughout bits 1 to 8.
- R6: After a select byte that is not accepted, the block ignores the bus until the next START, so a following byte is not acknowledged.
- R7: After an accepted write select, one address byte is received and acknowledged. When that acknowledge is released, acc_valid pulses once with acc_read=0 and acc_addr equal to the byte.
- R8: After an accepted read select, acc_valid pulses once when the select acknowledge is released, with acc_read=1 and acc_addr=0.
- R9: A STOP at any point aborts the current byte: sda_oe drops and no report is produced for that transaction.
- R10: A repeated START at any point restarts select code reception, and the new transaction proceeds normally.
- R11: acc_valid is high for exactly one clock per report. After reset, sda_oe=0 and acc_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock line level |
| sda_i | input | 1 | Raw serial data line level |
| chip_sel | input | 3 | Strapped slave address, compared with select bits [3:1] |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| acc_valid | output | 1 | Single-cycle report strobe |
| acc_region | output | 1 | 0 main memory, 1 identification page |
| acc_read | output | 1 | 1 read access, 0 write access |
| acc_addr | output | 8 | Captured word address (0 for reads) |

## Verification
A wrong sequencer state shows up on the bus within one byte. The failure can take three forms: an acknowledge missing or present in the 9th bit of the byte concerned, an acknowledge edge in the wrong SCL phase, or a report strobe appearing, missing or doubled after the acknowledge is released. A bit counter that is off by one shifts the received byte. That surfaces as a refused select code or a wrong acc_addr at the first report. A stale capture register surfaces as a wrong acc_region or acc_read on the next report.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;

    localparam int BYTE_W = 8;
    localparam int CE_W   = 3;
    localparam int TYPE_W = 4;
    localparam logic [TYPE_W-1:0] TYPE_MEM = 4'b1010;
    localparam logic [TYPE_W-1:0] TYPE_ID  = 4'b1011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HOLD
    } fe_state_t;

    typedef enum logic {
        REG_MEM = 1'b0,
        REG_ID  = 1'b1
    } region_t;

    typedef struct packed {
        logic [TYPE_W-1:0] dtype;
        logic [CE_W-1:0]   ce;
        logic              rw;
    } sel_code_t;

    typedef struct packed {
        logic    hit;
        region_t region;
        logic    rd;
    } sel_dec_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        region_t           region;
        logic              rd;
        logic [BYTE_W-1:0] addr;
    } access_t;

    function automatic sel_dec_t decode_sel(input sel_code_t c,
                                            input logic [CE_W-1:0] pins);
        sel_dec_t d;
        d.hit    = ((c.dtype == TYPE_MEM) || (c.dtype == TYPE_ID)) && (c.ce == pins);
        d.region = (c.dtype == TYPE_ID) ? REG_ID : REG_MEM;
        d.rd     = c.rw;
        return d;
    endfunction

endpackage

// File: rtl/i2cfe_sync.sv
module i2cfe_sync
    import i2cfe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_raw;
                    sda_chain <= sda_raw;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
                    sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_prev;
        ev.scl_fall = ~scl_s & scl_prev;
        ev.start    = scl_s & scl_prev & sda_prev & ~sda_s;
        ev.stop     = scl_s & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/i2cfe_shift.sv
module i2cfe_shift #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic [BYTE_W-1:0] data,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W + 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (bit_stb && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (!clr && bit_stb && cnt < CNT_W'(BYTE_W)) begin
            data <= {data[BYTE_W-2:0], bit_val};
        end
    end
endmodule

// File: rtl/i2cfe_ctrl.sv
module i2cfe_ctrl
    import i2cfe_pkg::*;
#(
    localparam int CNT_W = $clog2(BYTE_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CE_W-1:0]   pins,
    output logic              shift_clr,
    output logic              oe,
    output logic              valid,
    output access_t           acc
);
    fe_state_t state;
    sel_dec_t  dec;
    logic      byte_end;
    logic      ack_end;

    assign dec      = decode_sel(sel_code_t'(data), pins);
    assign byte_end = ev.scl_fall && (cnt == CNT_W'(BYTE_W));
    assign ack_end  = ev.scl_fall && (cnt == CNT_W'(BYTE_W + 1));

    always_comb begin
        shift_clr = ev.start || ev.stop || (state == ST_IDLE) || (state == ST_HOLD);
        if ((state == ST_SEL_ACK || state == ST_ADDR_ACK) && ack_end) begin
            shift_clr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            oe    <= 1'b0;
            valid <= 1'b0;
            acc   <= '0;
        end else begin
            valid <= 1'b0;
            if (ev.start) begin
                state <= ST_SEL;
                oe    <= 1'b0;
            end else if (ev.stop) begin
                state <= ST_IDLE;
                oe    <= 1'b0;
            end else begin
                case (state)
                    ST_SEL: if (byte_end) begin
                        if (dec.hit) begin
                            state      <= ST_SEL_ACK;
                            oe         <= 1'b1;
                            acc.region <= dec.region;
                            acc.rd     <= dec.rd;
                            acc.addr   <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_SEL_ACK: if (ack_end) begin
                        oe <= 1'b0;
                        if (acc.rd) begin
                            valid <= 1'b1;
                            state <= ST_HOLD;
                        end else begin
                            state <= ST_ADDR;
                        end
                    end
                    ST_ADDR: if (byte_end) begin
                        oe       <= 1'b1;
                        acc.addr <= data;
                        state    <= ST_ADDR_ACK;
                    end
                    ST_ADDR_ACK: if (ack_end) begin
                        oe    <= 1'b0;
                        valid <= 1'b1;
                        state <= ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_sel_frontend.sv
module i2c_sel_frontend
    import i2cfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [CE_W-1:0]   chip_sel,
    output logic              sda_oe,
    output logic              acc_valid,
    output logic              acc_region,
    output logic              acc_read,
    output logic [BYTE_W-1:0] acc_addr
);
    localparam int CNT_W = $clog2(BYTE_W + 2);

    bus_ev_t           ev;
    logic [BYTE_W-1:0] sh_data;
    logic [CNT_W-1:0]  sh_cnt;
    logic              sh_clr;
    access_t           acc;
    logic              bus_start;
    logic              bus_stop;
    logic              bus_scl;

    i2cfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .ev      (ev)
    );

    i2cfe_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clr     (sh_clr),
        .bit_stb (ev.scl_rise),
        .bit_val (ev.sda),
        .data    (sh_data),
        .cnt     (sh_cnt)
    );

    i2cfe_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .data      (sh_data),
        .cnt       (sh_cnt),
        .pins      (chip_sel),
        .shift_clr (sh_clr),
        .oe        (sda_oe),
        .valid     (acc_valid),
        .acc       (acc)
    );

    assign acc_region = acc.region;
    assign acc_read   = acc.rd;
    assign acc_addr   = acc.addr;
    assign bus_start  = ev.start;
    assign bus_stop   = ev.stop;
    assign bus_scl    = ev.scl;
endmodule

// File: rtl/i2cfe_chk.sv
module i2cfe_chk (
    input logic clk,
    input logic rst,
    input logic bus_start,
    input logic bus_stop,
    input logic bus_scl,
    input logic sda_oe,
    input logic acc_valid
);
    AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (bus_scl && $past(bus_scl)) |-> $stable(sda_oe)); // R5
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> !acc_valid); // R11
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> (!sda_oe && !acc_valid)); // R9
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> (!sda_oe && !acc_valid)); // R10
    AST_VALID_ENDS_ACK: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (!sda_oe && $past(sda_oe))); // R7
endmodule

bind i2c_sel_frontend i2cfe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .bus_scl   (bus_scl),
    .sda_oe    (sda_oe),
    .acc_valid (acc_valid)
);

// File: tb/i2c_sel_frontend_bench.sv
module i2c_sel_frontend_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [7:0] sel;
        logic [7:0] adr;
        logic       ack;
    } vec_t;

    // chip_sel strapped to 3'b101 for the table
    localparam vec_t VECS [NVEC] = '{
        '{sel: 8'hAA, adr: 8'h3C, ack: 1'b1},
        '{sel: 8'hBA, adr: 8'h81, ack: 1'b1},
        '{sel: 8'hAB, adr: 8'h00, ack: 1'b1},
        '{sel: 8'hBB, adr: 8'h00, ack: 1'b1},
        '{sel: 8'hCA, adr: 8'h11, ack: 1'b0},
        '{sel: 8'hA8, adr: 8'h22, ack: 1'b0},
        '{sel: 8'h9A, adr: 8'h33, ack: 1'b0},
        '{sel: 8'hAE, adr: 8'h44, ack: 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] chip_sel = 3'b101;
    logic       sda_oe, acc_valid, acc_region, acc_read;
    logic [7:0] acc_addr;
    logic       sda_bus;

    int checks = 0;
    int failures = 0;
    int vcount = 0;
    int dbl = 0;
    logic prev_valid = 1'b0;
    logic last_region, last_read;
    logic [7:0] last_addr;
    logic done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_sel_frontend u_i2c_sel_frontend (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .chip_sel(chip_sel), .sda_oe(sda_oe), .acc_valid(acc_valid),
        .acc_region(acc_region), .acc_read(acc_read), .acc_addr(acc_addr)
    );

    always @(negedge clk) begin
        if (acc_valid) begin
            vcount++;
            last_region = acc_region;
            last_read = acc_read;
            last_addr = acc_addr;
            if (prev_valid) dbl++;
        end
        prev_valid = acc_valid;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    // early: sda_oe seen during bits 1..8; ack sampled in 9th high phase
    task automatic send_bits(input logic [7:0] b, input int n,
                             output logic ack, output logic early);
        early = 1'b0;
        ack = 1'b0;
        for (int k = 7; k > 7 - n; k--) begin
            sda_m = b[k]; wq();
            if (sda_oe) early = 1'b1;
            scl_m = 1'b1; wq();
            if (sda_oe) early = 1'b1;
            scl_m = 1'b0; wq();
        end
        if (n == 8) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
            ack = ~sda_bus;
            scl_m = 1'b0; wq();
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic ack, early;
        int n0;
        vec_t v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sda_oe == 1'b0, "R11 reset sda_oe", sda_oe, 0);
        chk(acc_valid == 1'b0, "R11 reset acc_valid", acc_valid, 0);

        // R1: bits without START are ignored
        scl_m = 1'b0; wq();
        send_bits(8'hAA, 8, ack, early);
        chk(ack == 1'b0, "R1 no ack before start", ack, 0);
        chk(vcount == 0, "R1 no report before start", vcount, 0);
        scl_m = 1'b1; wq();

        // table walk (R2 R3 R4 R5 R7 R8)
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            n0 = vcount;
            i2c_start();
            send_bits(v.sel, 8, ack, early);
            chk(ack == v.ack, "R3 R4 select ack", ack, v.ack);
            chk(early == 1'b0, "R5 no drive in bits 1-8", early, 0);
            chk(sda_oe == 1'b0, "R5 release after bit 9", sda_oe, 0);
            if (v.ack && !v.sel[0]) begin
                send_bits(v.adr, 8, ack, early);
                chk(ack == 1'b1, "R7 address ack", ack, 1);
                chk(early == 1'b0, "R5 no drive in address bits", early, 0);
            end
            i2c_stop();
            chk(vcount == n0 + (v.ack ? 1 : 0), "R7 R8 report count", vcount, n0 + (v.ack ? 1 : 0));
            if (v.ack) begin
                chk(last_region == v.sel[4], "R3 region", last_region, v.sel[4]);
                chk(last_read == v.sel[0], "R2 direction", last_read, v.sel[0]);
                chk(last_addr == (v.sel[0] ? 8'h00 : v.adr), "R7 R8 address", last_addr,
                    v.sel[0] ? 0 : v.adr);
            end
        end

        // R4: different strap value
        chip_sel = 3'b000;
        n0 = vcount;
        i2c_start();
        send_bits(8'hA1, 8, ack, early);
        chk(ack == 1'b1, "R4 strap 000 ack", ack, 1);
        i2c_stop();
        chk(vcount == n0 + 1 && last_read == 1'b1, "R8 read report strap 000", vcount - n0, 1);

        // R6: after a refused select, a following byte is ignored
        n0 = vcount;
        i2c_start();
        send_bits(8'hAA, 8, ack, early);
        chk(ack == 1'b0, "R6 refused select", ack, 0);
        send_bits(8'hA0, 8, ack, early);
        chk(ack == 1'b0, "R6 ignored until start", ack, 0);
        i2c_stop();
        chk(vcount == n0, "R6 no report", vcount, n0);

        // R9: STOP in the middle of a select byte
        n0 = vcount;
        i2c_start();
        send_bits(8'hA0, 4, ack, early);
        i2c_stop();
        chk(sda_oe == 1'b0, "R9 stop releases", sda_oe, 0);
        i2c_start();
        send_bits(8'hA0, 8, ack, early);
        chk(ack == 1'b1, "R9 fresh select after stop", ack, 1);
        send_bits(8'h5A, 8, ack, early);
        i2c_stop();
        chk(vcount == n0 + 1 && last_addr == 8'h5A, "R9 report after abort", last_addr, 8'h5A);

        // R10: repeated START in the middle of an address byte
        n0 = vcount;
        i2c_start();
        send_bits(8'hB0, 8, ack, early);
        chk(ack == 1'b1, "R10 first select ack", ack, 1);
        send_bits(8'hF0, 3, ack, early);
        i2c_start();
        send_bits(8'hA0, 8, ack, early);
        chk(ack == 1'b1, "R10 select after repeated start", ack, 1);
        send_bits(8'h77, 8, ack, early);
        chk(ack == 1'b1, "R10 address ack", ack, 1);
        i2c_stop();
        chk(vcount == n0 + 1, "R10 single report", vcount - n0, 1);
        chk(last_region == 1'b0 && last_addr == 8'h77, "R10 new transaction fields", last_addr, 8'h77);

        chk(dbl == 0, "R11 strobe width", dbl, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule